// File: doc/BRIEF.md
# Robbed-Bit Transmit Signaling Inserter

This block places per-channel signaling bits into an outgoing 24-channel T1 byte stream. It replaces the least significant bit of a channel byte in the signaling frames of each multiframe. The host writes the signaling for all channels into a bank of twelve 8-bit registers. Each register covers eight channels of one signaling group. The inserter never reads those registers directly. At a multiframe boundary the whole bank is copied into a shadow bank, and the inserter reads only from that copy. The host may therefore rewrite the registers at any time without changing the multiframe already in progress.

Two framing modes are supported. In the 24-frame extended mode, every multiframe loads the shadow and carries four bits per channel (A, B, C, D). In the 12-frame mode, the shadow loads every other multiframe. The first multiframe sends the A and B groups. The second sends the A/C and B/D groups in the A and B positions. A one-cycle interrupt pulse follows each load, so the host knows when fresh values may be written.

Top module: `rbs_tx_inserter`

## Requirements
- R1: Host register address = group*3 + channel/8, with bit = channel mod 8. Group 0 is A, group 1 is B, group 2 is A/C and group 3 is B/D. Writes to addresses 12 to 15 change nothing.
- R2: With `esf_mode`=1 and `ins_en`=1, the LSB of each valid byte is replaced in frame indices 5, 11, 17 and 23 (0-based). The source is the shadow bit of groups 0, 1, 2 and 3 respectively.
- R3: With `esf_mode`=0, frame indices 5 and 11 carry groups 0 and 1 in the first multiframe after a load. They carry groups 2 and 3 in the following multiframe.
- R4: Bits 7..1 of every byte always pass unchanged. The LSB passes unchanged in all non-signaling frames.
- R5: With `ins_en`=0, every byte passes through unmodified.
- R6: A load boundary is a valid byte with frame 0 and channel 0. In extended mode every boundary loads the shadow. In 12-frame mode every other boundary loads, starting with the first boundary after reset or after extended mode.
- R7: A host write never alters bits sent before the next load. This includes a write in the same cycle as a load boundary, which takes effect only at the following load.
- R8: `mf_irq` is a one-cycle pulse. It is high in the cycle after each loading boundary byte is accepted, and low otherwise.
- R9: Outputs are registered with one cycle of latency, and `out_valid` follows `in_valid`. During reset, `out_valid`, `out_byte` and `mf_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host register write data |
| esf_mode | input | 1 | 1 = 24-frame mode, 0 = 12-frame mode |
| ins_en | input | 1 | Signaling insertion enable |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Outgoing channel byte |
| in_chan | input | 5 | Channel index 0..23 |
| in_frame | input | 5 | Frame index in multiframe, 0-based |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Byte with signaling inserted |
| mf_irq | output | 1 | Transmit multiframe pulse |

## Verification
The bench writes host registers in the middle of a multiframe and also in the exact cycle of a load boundary. A design that read the live registers, or that let the write win over the load, would change bits mid-multiframe. The 12-frame mode runs across several multiframe pairs. A design that reloaded every multiframe, or that inverted the half, would send A/B where C/D belong. Idle gaps, a disabled multiframe and a sparse single-bit pattern expose wrong group or bit mapping, wrong frame selection and insertion leaking through while disabled.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    GRP_A  = 2'd0,
    GRP_B  = 2'd1,
    GRP_AC = 2'd2,
    GRP_BD = 2'd3
  } sig_grp_e;

  localparam int NUM_GROUPS = 4;
endpackage

// File: rtl/rbs_reg_bank.sv
module rbs_reg_bank #(
  parameter int NUM_REG  = 12,
  parameter int REG_BITS = 8,
  localparam int AW      = $clog2(NUM_REG + 1),
  localparam int FLAT_W  = NUM_REG * REG_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [REG_BITS-1:0] wr_data,
  input  logic                load,
  output logic [FLAT_W-1:0]   shadow_flat
);
  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    logic [REG_BITS-1:0] host_q;
    logic [REG_BITS-1:0] shad_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        host_q <= '0;
        shad_q <= '0;
      end else begin
        if (wr_en && (wr_addr == AW'(i))) host_q <= wr_data;
        if (load) shad_q <= host_q;
      end
    end
    assign shadow_flat[i*REG_BITS +: REG_BITS] = shad_q;
  end

  // R7: shadow contents change only on a load
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow_flat));
endmodule

// File: rtl/rbs_mf_tracker.sv
module rbs_mf_tracker #(
  parameter int CH_W = 5,
  parameter int FR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [CH_W-1:0] in_chan,
  input  logic [FR_W-1:0] in_frame,
  input  logic            esf_mode,
  output logic            load,
  output logic            second_half,
  output logic            irq
);
  logic bnd;
  assign bnd  = in_valid && (in_chan == '0) && (in_frame == '0);
  assign load = bnd && (esf_mode || second_half);

  always_ff @(posedge clk) begin
    if (rst) begin
      second_half <= 1'b1;
      irq         <= 1'b0;
    end else begin
      irq <= load;
      if (bnd) second_half <= esf_mode ? 1'b1 : ~second_half;
    end
  end

  // R8: pulse only after a boundary byte
  a_r8_irq_at_boundary: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(in_valid && (in_chan == '0) && (in_frame == '0)));
  // R6: 12-frame boundaries alternate the half
  a_r6_d4_alternate: assert property (@(posedge clk) disable iff (rst)
    (bnd && !esf_mode) |=> (second_half != $past(second_half)));
  // R6: a 12-frame load always starts a first half
  a_r6_d4_load_first: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(esf_mode)) |-> !second_half);
endmodule

// File: rtl/rbs_bit_sel.sv
module rbs_bit_sel #(
  parameter int NUM_CH     = 24,
  parameter int CH_PER_REG = 8,
  parameter int REG_BITS   = 8,
  parameter int SIG_PERIOD = 6,
  parameter int CH_W       = 5,
  parameter int FR_W       = 5,
  localparam int REGS_PER_GRP = NUM_CH / CH_PER_REG,
  localparam int NUM_REG      = rbs_pkg::NUM_GROUPS * REGS_PER_GRP,
  localparam int FLAT_W       = NUM_REG * REG_BITS,
  localparam int IDX_W        = $clog2(FLAT_W)
) (
  input  logic [FLAT_W-1:0] shadow_flat,
  input  logic [CH_W-1:0]   chan,
  input  logic [FR_W-1:0]   frame,
  input  logic              esf_mode,
  input  logic              second_half,
  output logic              hit,
  output logic              sig_bit
);
  int fi, k, grp_i;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit   = 1'b0;
    grp_i = 0;
    fi    = int'(frame) + 1;
    k     = fi / SIG_PERIOD - 1;
    if ((fi % SIG_PERIOD) == 0 && int'(chan) < NUM_CH) begin
      if (esf_mode) begin
        hit   = (k < rbs_pkg::NUM_GROUPS);
        grp_i = k;
      end else begin
        hit   = (k < 2);
        grp_i = second_half ? k + 2 : k;
      end
    end
    idx = '0;
    if (hit)
      idx = IDX_W'((grp_i * REGS_PER_GRP + int'(chan) / CH_PER_REG) * REG_BITS
                   + int'(chan) % CH_PER_REG);
    sig_bit = hit ? shadow_flat[idx] : 1'b0;
  end
endmodule

// File: rtl/rbs_tx_inserter.sv
module rbs_tx_inserter #(
  parameter int NUM_CH     = 24,
  parameter int CH_PER_REG = 8,
  parameter int REG_BITS   = 8,
  parameter int ESF_FRAMES = 24,
  parameter int SIG_PERIOD = 6,
  localparam int REGS_PER_GRP = NUM_CH / CH_PER_REG,
  localparam int NUM_REG      = rbs_pkg::NUM_GROUPS * REGS_PER_GRP,
  localparam int AW           = $clog2(NUM_REG + 1),
  localparam int CH_W         = $clog2(NUM_CH),
  localparam int FR_W         = $clog2(ESF_FRAMES),
  localparam int FLAT_W       = NUM_REG * REG_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_we,
  input  logic [AW-1:0]       host_addr,
  input  logic [REG_BITS-1:0] host_wdata,
  input  logic                esf_mode,
  input  logic                ins_en,
  input  logic                in_valid,
  input  logic [7:0]          in_byte,
  input  logic [CH_W-1:0]     in_chan,
  input  logic [FR_W-1:0]     in_frame,
  output logic                out_valid,
  output logic [7:0]          out_byte,
  output logic                mf_irq
);
  logic              load, second_half, hit, sig_bit;
  logic [FLAT_W-1:0] shadow_flat;

  rbs_reg_bank #(.NUM_REG(NUM_REG), .REG_BITS(REG_BITS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(host_we), .wr_addr(host_addr),
    .wr_data(host_wdata), .load(load), .shadow_flat(shadow_flat));

  rbs_mf_tracker #(.CH_W(CH_W), .FR_W(FR_W)) u_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_frame(in_frame), .esf_mode(esf_mode), .load(load),
    .second_half(second_half), .irq(mf_irq));

  rbs_bit_sel #(.NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .REG_BITS(REG_BITS),
                .SIG_PERIOD(SIG_PERIOD), .CH_W(CH_W), .FR_W(FR_W)) u_sel (
    .shadow_flat(shadow_flat), .chan(in_chan), .frame(in_frame),
    .esf_mode(esf_mode), .second_half(second_half), .hit(hit),
    .sig_bit(sig_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      out_byte  <= (in_valid && ins_en && hit) ? {in_byte[7:1], sig_bit} : in_byte;
    end
  end

  // R4: upper bits always pass through
  a_r4_upper_pass: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_byte[7:1] == $past(in_byte[7:1])));
  // R5: disabled insertion leaves bytes untouched
  a_r5_disabled_pass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(ins_en)) |-> (out_byte == $past(in_byte)));
endmodule

// File: tb/rbs_tx_inserter_tb.sv
module rbs_tx_inserter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 24;

  logic clk = 0, rst = 1;
  logic host_we = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic esf_mode = 1, ins_en = 1, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic [4:0] in_chan = 0, in_frame = 0;
  logic out_valid, mf_irq;
  logic [7:0] out_byte;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] m_host [12];
  logic [7:0] m_shad [12];
  bit m_half = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbs_tx_inserter u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .esf_mode(esf_mode), .ins_en(ins_en),
    .in_valid(in_valid), .in_byte(in_byte), .in_chan(in_chan),
    .in_frame(in_frame), .out_valid(out_valid), .out_byte(out_byte),
    .mf_irq(mf_irq));

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic int m_grp(int fr, bit esf, bit half);
    int k;
    if (((fr + 1) % 6) != 0) return -1;
    k = (fr + 1) / 6 - 1;
    if (esf) return (k < 4) ? k : -1;
    return (k < 2) ? (half ? k + 2 : k) : -1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, sample at next negedge
  task automatic step(bit v, logic [7:0] b, int ch, int fr, bit we, int addr,
                      logic [7:0] wd, string sig_tag);
    logic [7:0] exp_b;
    bit exp_irq, bnd;
    int g;
    string tag;
    in_valid = v; in_byte = b; in_chan = 5'(ch); in_frame = 5'(fr);
    host_we = we; host_addr = 4'(addr); host_wdata = wd;
    g = m_grp(fr, esf_mode, m_half);
    exp_b = b;
    tag = ins_en ? "R4" : "R5";
    if (v && ins_en && g >= 0 && ch < NCH) begin
      exp_b[0] = m_shad[g*3 + ch/8][ch%8];
      tag = sig_tag;
    end
    bnd = v && ch == 0 && fr == 0;
    exp_irq = bnd && (esf_mode || m_half);
    if (exp_irq) for (int i = 0; i < 12; i++) m_shad[i] = m_host[i];
    if (bnd) m_half = esf_mode ? 1'b1 : ~m_half;
    if (we && addr < 12) m_host[addr] = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag, {23'd0, out_valid, out_byte}, {23'd0, 1'(v), exp_b});
    check(esf_mode ? "R8" : "R6", 32'(mf_irq), 32'(exp_irq));
  endtask

  // one multiframe; host write at flat byte index wr_at (-1 = none)
  task automatic run_mf(int wr_at, int addr, logic [7:0] wd, string sig_tag);
    int nfr = esf_mode ? 24 : 12;
    int n = 0;
    for (int f = 0; f < nfr; f++)
      for (int c = 0; c < NCH; c++) begin
        if (($urandom % 16) == 0 && n != 0)
          step(0, 8'($urandom), int'($urandom % 24), 0, 0, 0, 0, sig_tag);
        step(1, 8'($urandom), c, f, n == wr_at, addr, wd, sig_tag);
        n++;
      end
  endtask

  task automatic host_write(int addr, logic [7:0] wd);
    step(0, 0, 1, 1, 1, addr, wd, "R1");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 12; i++) begin m_host[i] = 0; m_shad[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {23'd0, out_valid, out_byte}, 32'd0);
    check("R9", 32'(mf_irq), 32'd0);
    rst = 0;

    // R1: sparse pattern, channel 10 D bit and channel 17 A bit
    esf_mode = 1; ins_en = 1;
    host_write(10, 8'h04);
    host_write(2, 8'h02);
    host_write(13, 8'hFF);
    run_mf(-1, 0, 0, "R1");
    // R2: random contents, several multiframes
    for (int i = 0; i < 12; i++) host_write(i, 8'($urandom));
    run_mf(-1, 0, 0, "R2");
    // R7: write mid-multiframe, then exactly on the boundary byte
    run_mf(200, 3, 8'($urandom), "R7");
    run_mf(0, 7, 8'($urandom), "R7");
    run_mf(-1, 0, 0, "R2");
    // R3: 12-frame mode, multiframe pairs with writes inside
    esf_mode = 0;
    for (int i = 0; i < 12; i++) host_write(i, 8'($urandom));
    run_mf(-1, 0, 0, "R3");
    run_mf(-1, 0, 0, "R3");
    run_mf(30, 8, 8'($urandom), "R7");
    run_mf(100, 0, 8'($urandom), "R7");
    run_mf(0, 11, 8'($urandom), "R7");
    run_mf(-1, 0, 0, "R3");
    // R5: insertion disabled
    ins_en = 0;
    run_mf(-1, 0, 0, "R5");
    run_mf(-1, 0, 0, "R5");
    // R6: back to extended mode loads every boundary
    ins_en = 1; esf_mode = 1;
    run_mf(-1, 0, 0, "R6");
    run_mf(-1, 0, 0, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule